// File: doc/BRIEF.md
# Serial Text Field Seeder

This block sits in front of a cellular-automaton field and seeds it from a text picture sent over an asynchronous serial line. It contains its own receiver. The line is first passed through a two-flop synchronizer. A falling edge starts a frame, and each bit is sampled near its middle, timed by a divisor equal to the clock frequency over the baud rate. The stop bit is then checked. Every received byte is classified. An asterisk becomes a live cell and a hyphen becomes a dead cell. Anything else, such as row labels, spaces, carriage returns or line feeds, is thrown away.

Accepted cells leave the block as a one-cycle valid pulse that carries the cell value. This pulse feeds the field's scan chain directly. Cells are produced only while the load control is held. Once a full field of cells has been produced, a done flag rises and all later symbols are ignored. The flag clears only when the load control is released, and a fresh fill starts when the control is asserted again.

The receiver FSM has five states, named RX_IDLE, RX_START, RX_DATA, RX_STOP and RX_BREAK:
- RX_IDLE moves to RX_START on a low line.
- RX_START returns to RX_IDLE if the line is high at half a bit; otherwise it moves to RX_DATA.
- RX_DATA moves to RX_STOP after the eighth bit.
- RX_STOP moves to RX_IDLE when the stop bit reads high, and to RX_BREAK when it reads low.
- RX_BREAK moves to RX_IDLE once the line is high again.

The fill FSM has three states, named FL_IDLE, FL_FILL and FL_FULL:
- FL_IDLE moves to FL_FILL while the load control is high.
- FL_FILL moves to FL_FULL on the last cell, and to FL_IDLE when the load control is released.
- FL_FULL moves to FL_IDLE when the load control is released.

Top module: `text_seed_loader`

## Requirements
- R1: The line format is 1 start bit, 8 data bits sent least significant bit first, and 1 stop bit, with no parity. The bit time is CLK_HZ/BAUD clocks, and each bit is sampled near its centre after a two-flop synchronizer. For example, byte 0x54 (the bit-reversed form of 0x2A) must not be read as a live cell.
- R2: A byte of value 0x2A ('*') received while filling produces exactly one pulse on `cell_valid`, with `cell_bit` = 1.
- R3: A byte of value 0x2D ('-') received while filling produces exactly one pulse on `cell_valid`, with `cell_bit` = 0.
- R4: Any other byte value produces no pulse and does not advance the cell count.
- R5: A frame whose stop bit reads low is discarded without producing a cell. The receiver waits for the line to return high before it looks for the next start bit.
- R6: No cell is produced while `load_hold` is low.
- R7: `load_done` goes high in the same cycle as the pulse of the FIELD_W*FIELD_H-th cell. While it stays high, no further pulse is produced.
- R8: Lowering `load_hold` clears `load_done` and the cell count by the next clock. Raising it again starts a fresh fill from zero.
- R9: `cell_valid` is never high on two consecutive cycles, and each frame yields at most one pulse.
- R10: A low glitch shorter than half a bit time is rejected as a false start and produces no byte.
- R11: After reset, `cell_valid`, `cell_bit` and `load_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| load_hold | input | 1 | Load control; cells are produced only while high |
| cell_valid | output | 1 | One-cycle pulse marking a new cell |
| cell_bit | output | 1 | Cell value: 1 is live, 0 is dead |
| load_done | output | 1 | High once a full field of cells has been produced |

## Verification
The two meaningful symbols are sent next to near misses: 0x2B, a line feed, and 0x54, the bit-reversed form of 0x2A. Together these separate correct classification and correct bit order from a receiver that shifts in the wrong direction or decodes too loosely. A frame with a low stop bit and a short start glitch check that framing errors and false starts yield nothing. Symbols are sent with the load control low, past the end of a full field, and across a release-and-reassert. This shows that gating, saturation at the field size and restart from zero each behave independently.

// File: rtl/seed_pkg.sv
package seed_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_BREAK
    } rx_state_t;

    typedef enum logic [1:0] {
        FL_IDLE,
        FL_FILL,
        FL_FULL
    } fill_state_t;

    localparam logic [7:0] SYM_LIVE = 8'h2A;
    localparam logic [7:0] SYM_DEAD = 8'h2D;

endpackage

// File: rtl/rx_sync2.sv
module rx_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic d_sync
);
    logic meta;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta   <= 1'b1;
            d_sync <= 1'b1;
        end else begin
            meta   <= d_async;
            d_sync <= meta;
        end
    end
endmodule

// File: rtl/serial_byte_rx.sv
module serial_byte_rx
    import seed_pkg::*;
#(
    parameter int CLK_HZ = 50_000_000,
    parameter int BAUD   = 115_200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_s,
    output logic       byte_stb,
    output logic [7:0] byte_val
);
    localparam int DIV  = CLK_HZ / BAUD;
    localparam int HALF = DIV / 2;
    localparam int CW   = $clog2(DIV + 1);

    rx_state_t      st, st_nx;
    logic [CW-1:0]  tick;
    logic [2:0]     bit_idx;
    logic [7:0]     shreg;
    logic           at_half, at_full;

    assign at_half = (tick == CW'(HALF - 1));
    assign at_full = (tick == CW'(DIV - 1));

    always_comb begin
        st_nx = st;
        unique case (st)
            RX_IDLE:  if (!rx_s) st_nx = RX_START;
            RX_START: if (at_half) st_nx = rx_s ? RX_IDLE : RX_DATA;
            RX_DATA:  if (at_full && bit_idx == 3'd7) st_nx = RX_STOP;
            RX_STOP:  if (at_full) st_nx = rx_s ? RX_IDLE : RX_BREAK;
            RX_BREAK: if (rx_s) st_nx = RX_IDLE;
            default:  st_nx = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= RX_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick     <= '0;
            bit_idx  <= '0;
            shreg    <= '0;
            byte_stb <= 1'b0;
            byte_val <= '0;
        end else begin
            byte_stb <= 1'b0;
            unique case (st)
                RX_IDLE, RX_BREAK: begin
                    tick    <= '0;
                    bit_idx <= '0;
                end
                RX_START: begin
                    tick <= at_half ? '0 : tick + CW'(1);
                end
                RX_DATA: begin
                    if (at_full) begin
                        tick    <= '0;
                        shreg   <= {rx_s, shreg[7:1]};
                        bit_idx <= bit_idx + 3'd1;
                    end else begin
                        tick <= tick + CW'(1);
                    end
                end
                RX_STOP: begin
                    if (at_full) begin
                        tick <= '0;
                        if (rx_s) begin
                            byte_stb <= 1'b1;
                            byte_val <= shreg;
                        end
                    end else begin
                        tick <= tick + CW'(1);
                    end
                end
                default: tick <= '0;
            endcase
        end
    end

    // R5: a byte is only released after a high stop sample
    assert_stop_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        byte_stb |-> $past(rx_s));

    // R9: byte strobes never come back to back
    assert_byte_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        byte_stb |=> !byte_stb);

    // R10: a start that fails the half-bit check yields no data phase
    assert_false_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RX_START && at_half && rx_s) |=> (st == RX_IDLE));
endmodule

// File: rtl/cell_fill_ctrl.sv
module cell_fill_ctrl
    import seed_pkg::*;
#(
    parameter int CELLS = 2048
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_hold,
    input  logic       byte_stb,
    input  logic [7:0] byte_val,
    output logic       cell_valid,
    output logic       cell_bit,
    output logic       load_done
);
    localparam int NW = $clog2(CELLS + 1);

    fill_state_t    st, st_nx;
    logic [NW-1:0]  filled;
    logic           is_live, is_dead, take, last;

    assign is_live = (byte_val == SYM_LIVE);
    assign is_dead = (byte_val == SYM_DEAD);
    assign take    = (st == FL_FILL) && load_hold && byte_stb && (is_live || is_dead);
    assign last    = (filled == NW'(CELLS - 1));

    always_comb begin
        st_nx = st;
        unique case (st)
            FL_IDLE: if (load_hold) st_nx = FL_FILL;
            FL_FILL: begin
                if (!load_hold)        st_nx = FL_IDLE;
                else if (take && last) st_nx = FL_FULL;
            end
            FL_FULL: if (!load_hold) st_nx = FL_IDLE;
            default: st_nx = FL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= FL_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cell_valid <= 1'b0;
            cell_bit   <= 1'b0;
            filled     <= '0;
        end else begin
            cell_valid <= take;
            if (take) cell_bit <= is_live;
            if (st == FL_IDLE)  filled <= '0;
            else if (take)      filled <= filled + NW'(1);
        end
    end

    assign load_done = (st == FL_FULL);

    // R9: one-cycle cell pulses
    assert_cell_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cell_valid |=> !cell_valid);

    // R6: a cell implies the load control was held when it was taken
    assert_armed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cell_valid |-> $past(load_hold));

    // R7: quiet once the field is full
    assert_quiet_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_done && $past(load_done)) |-> !cell_valid);

    // R8: release clears the done flag
    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !load_hold |=> !load_done);
endmodule

// File: rtl/text_seed_loader.sv
module text_seed_loader
    import seed_pkg::*;
#(
    parameter int CLK_HZ  = 50_000_000,
    parameter int BAUD    = 115_200,
    parameter int FIELD_W = 64,
    parameter int FIELD_H = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_line,
    input  logic load_hold,
    output logic cell_valid,
    output logic cell_bit,
    output logic load_done
);
    localparam int CELLS = FIELD_W * FIELD_H;

    logic       rx_s;
    logic       byte_stb;
    logic [7:0] byte_val;

    rx_sync2 u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (rx_line),
        .d_sync  (rx_s)
    );

    serial_byte_rx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_s     (rx_s),
        .byte_stb (byte_stb),
        .byte_val (byte_val)
    );

    cell_fill_ctrl #(.CELLS(CELLS)) u_fill (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_hold  (load_hold),
        .byte_stb   (byte_stb),
        .byte_val   (byte_val),
        .cell_valid (cell_valid),
        .cell_bit   (cell_bit),
        .load_done  (load_done)
    );

    // R2: a live cell follows a strobe of the live symbol
    assert_live_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_valid && cell_bit) |-> ($past(byte_stb) && $past(byte_val) == SYM_LIVE));

    // R3: a dead cell follows a strobe of the dead symbol
    assert_dead_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_valid && !cell_bit) |-> ($past(byte_stb) && $past(byte_val) == SYM_DEAD));
endmodule

// File: tb/text_seed_loader_test.sv
module text_seed_loader_test;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CLK_HZ = 16_000_000;
    localparam int BAUD   = 1_000_000;
    localparam int BIT_T  = CLK_HZ / BAUD;
    localparam int FW     = 4;
    localparam int FH     = 2;
    localparam int CELLS  = FW * FH;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_line = 1'b1;
    logic load_hold = 1'b0;
    logic cell_valid, cell_bit, load_done;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    bit exp_q[$];
    int exp_count = 0;
    bit exp_done = 1'b0;
    logic hold_q = 1'b0;

    always #2 clk = ~clk;

    text_seed_loader #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .FIELD_W(FW), .FIELD_H(FH)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_line    (rx_line),
        .load_hold  (load_hold),
        .cell_valid (cell_valid),
        .cell_bit   (cell_bit),
        .load_done  (load_done)
    );

    always @(posedge clk) hold_q <= load_hold;

    // per-clock comparison against the behavioural model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (!hold_q) begin
                exp_count = 0;
                exp_done  = 1'b0;
            end
            if (cell_valid) begin
                checks++;
                if (exp_q.size() == 0) begin
                    failures++;
                    $display("FAIL R4/R6/R7: unexpected cell pulse, actual bit=%0d expected none", cell_bit);
                end else begin
                    bit e;
                    e = exp_q.pop_front();
                    if (cell_bit !== e) begin
                        failures++;
                        $display("FAIL R2/R3: cell_bit actual=%0d expected=%0d", cell_bit, e);
                    end
                    exp_count++;
                    if (exp_count == CELLS) exp_done = 1'b1;
                end
            end
            checks++;
            if (load_done !== exp_done) begin
                failures++;
                $display("FAIL R7/R8: load_done actual=%0d expected=%0d", load_done, exp_done);
            end
        end
    end

    task automatic send_frame(input logic [7:0] b, input bit good_stop, input string req);
        if (good_stop && load_hold && (exp_q.size() + exp_count < CELLS) &&
            (b == 8'h2A || b == 8'h2D))
            exp_q.push_back(b == 8'h2A);
        @(negedge clk) rx_line = 1'b0;
        repeat (BIT_T) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_line = b[i];
            repeat (BIT_T) @(negedge clk);
        end
        rx_line = good_stop;
        repeat (BIT_T) @(negedge clk);
        rx_line = 1'b1;
        repeat (BIT_T + 8) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL %s: missing cell pulse for byte %h, actual none expected %0d",
                     req, b, exp_q.size());
            exp_q.delete();
        end
    endtask

    task automatic check_done(input bit e, input string req);
        @(negedge clk);
        checks++;
        if (load_done !== e) begin
            failures++;
            $display("FAIL %s: load_done actual=%0d expected=%0d", req, load_done, e);
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset values
        checks++;
        if (cell_valid !== 1'b0 || cell_bit !== 1'b0 || load_done !== 1'b0) begin
            failures++;
            $display("FAIL R11: outputs actual=%0d%0d%0d expected=000", cell_valid, cell_bit, load_done);
        end
        // R6: symbol while load control low
        send_frame(8'h2A, 1'b1, "R6");
        load_hold = 1'b1;
        repeat (4) @(negedge clk);
        send_frame(8'h2A, 1'b1, "R2");
        send_frame(8'h2D, 1'b1, "R3");
        send_frame(8'h54, 1'b1, "R1");
        send_frame(8'h2B, 1'b1, "R4");
        send_frame(8'h0A, 1'b1, "R4");
        send_frame(8'h2D, 1'b1, "R3");
        send_frame(8'h2A, 1'b0, "R5");
        // R10: short glitch
        @(negedge clk) rx_line = 1'b0;
        repeat (3) @(negedge clk);
        rx_line = 1'b1;
        repeat (3 * BIT_T) @(negedge clk);
        send_frame(8'h2A, 1'b1, "R10");
        send_frame(8'h2A, 1'b1, "R2");
        send_frame(8'h2D, 1'b1, "R3");
        send_frame(8'h2A, 1'b1, "R2");
        send_frame(8'h2D, 1'b1, "R7");
        check_done(1'b1, "R7");
        send_frame(8'h2A, 1'b1, "R7");
        check_done(1'b1, "R7");
        // R8: release and refill
        load_hold = 1'b0;
        repeat (3) @(negedge clk);
        check_done(1'b0, "R8");
        send_frame(8'h2D, 1'b1, "R6");
        load_hold = 1'b1;
        repeat (4) @(negedge clk);
        for (int k = 0; k < CELLS; k++)
            send_frame((k % 3 == 0) ? 8'h2A : 8'h2D, 1'b1, "R8");
        check_done(1'b1, "R8");
        repeat (10) @(negedge clk);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule